// File: doc/BRIEF.md
# Carrier Numerically Controlled Oscillator with Coarse Quadrature Table

This block generates the local carrier replica for one tracking channel of a bandpass-sampled satellite navigation correlator. A wide phase register advances by a software-supplied frequency word on every sample clock. Its three top bits select one of eight phase steps, and a small table turns each step into a coarse in-phase level and a coarse quadrature level, each one of ±1 or ±3. With a sample clock near 5.714 MHz and an aliased intermediate frequency near 1.405 MHz, the nominal frequency word is about 0.2459 · 2^27.

Every carry out of the phase register marks one whole carrier cycle and advances a wrapping cycle counter. On a latch strobe, the counter and the ten top phase bits are captured together. The tracking software reads this carrier measurement as a coherent pair. A new frequency word changes only the step size, so the phase continues from where it stood.

Top module: `carrier_nco`

## Requirements
- R1: While reset is held and right after it is released, the phase register and the cycle counter are zero. cos_out reads +3, sin_out reads +1, and cyc_snap and phase_snap read zero.
- R2: On each rising clock edge out of reset, the 27-bit phase register becomes its old value plus freq_word, taken modulo 2^27.
- R3: The phase step index is bits [26:24] of the phase register. For index 0 to 7, cos_out is +3, +1, -1, -3, -3, -1, +1, +3.
- R4: sin_out equals the cosine entry two steps earlier (index minus 2, modulo 8). For index 0 to 7 it reads +1, +3, +3, +1, -1, -3, -3, -1. Exactly one of the two outputs has magnitude 3 at any time.
- R5: A carry out of the phase register at an edge adds one to a 16-bit cycle counter at that same edge. The counter wraps from 65535 to 0.
- R6: When meas_latch is high at a rising edge, cyc_snap takes the cycle count and phase_snap takes phase register bits [26:17], both as they stood just before that edge. When meas_latch is low, both hold.
- R7: A change of freq_word takes effect at the next edge and does not clear or disturb the accumulated phase.
- R8: cos_out and sin_out are 3-bit two's complement values and take no values other than -3, -1, +1 and +3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; the phase advances once per edge |
| rst_n | input | 1 | Active-low synchronous reset |
| freq_word | input | 27 | Phase increment added on every edge |
| meas_latch | input | 1 | Captures cycle count and fine phase when high |
| cos_out | output | 3 | In-phase carrier level, signed |
| sin_out | output | 3 | Quadrature carrier level, signed |
| cyc_snap | output | 16 | Captured whole-cycle count |
| phase_snap | output | 10 | Captured fine phase (top phase bits) |

## Verification
A one-step-per-clock word walks all eight table entries. A design with a swapped or mis-shifted table would show a wrong level or a sine that leads instead of lags. Captures are taken on every clock and then withheld. A capture that read post-edge values, or one that kept sampling while the strobe was low, would be off by one step or would drift. The bench changes the frequency word mid-run at an arbitrary phase, which exposes an accumulator that restarts on a new word. A near-full-scale word pushes the cycle counter past 65535, so a counter that saturates, or one that misses carries, would report the wrong count after the wrap.

// File: rtl/nco_pkg.sv
package nco_pkg;
   localparam int LEVEL_W = 3;
   typedef logic signed [LEVEL_W-1:0] level_t;

   // cosine level for one of eight phase steps
   function automatic level_t cos_level(input int step);
      int k;
      k = step % 8;
      case (k)
         0, 7:    return  3'sd3;
         1, 6:    return  3'sd1;
         2, 5:    return -3'sd1;
         default: return -3'sd3;
      endcase
   endfunction

   // sine lags cosine by a quarter cycle (two steps)
   function automatic level_t sin_level(input int step);
      return cos_level(step + 6);
   endfunction
endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
   parameter int ACC_W = 27
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ACC_W-1:0] freq_i,
   output logic [ACC_W-1:0] acc_o,
   output logic             wrap_o
);
   localparam int SUM_W = ACC_W + 1;

   logic [SUM_W-1:0] sum_c;

   assign sum_c  = {1'b0, acc_o} + {1'b0, freq_i};
   assign wrap_o = sum_c[SUM_W-1];

   always_ff @(posedge clk) begin
      if (!rst_n) acc_o <= '0;
      else        acc_o <= sum_c[ACC_W-1:0];
   end
endmodule

// File: rtl/nco_trig_lut.sv
module nco_trig_lut
   import nco_pkg::*;
#(
   parameter int ADDR_W  = 3,
   parameter bit REG_OUT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] idx_i,
   output level_t            cos_o,
   output level_t            sin_o
);
   localparam int DEPTH = 1 << ADDR_W;

   level_t cos_rom [DEPTH];
   level_t sin_rom [DEPTH];
   level_t cos_c, sin_c;

   for (genvar k = 0; k < DEPTH; k++) begin : g_rom
      assign cos_rom[k] = cos_level(k);
      assign sin_rom[k] = sin_level(k);
   end

   assign cos_c = cos_rom[idx_i];
   assign sin_c = sin_rom[idx_i];

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cos_o <= cos_level(0);
            sin_o <= sin_level(0);
         end else begin
            cos_o <= cos_c;
            sin_o <= sin_c;
         end
      end
   end else begin : g_comb
      assign cos_o = cos_c;
      assign sin_o = sin_c;
   end
endmodule

// File: rtl/nco_meas_latch.sv
module nco_meas_latch #(
   parameter int CYC_W   = 16,
   parameter int PHASE_W = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wrap_i,
   input  logic [PHASE_W-1:0] phase_i,
   input  logic               latch_i,
   output logic [CYC_W-1:0]   cyc_cnt_o,
   output logic [CYC_W-1:0]   cyc_snap_o,
   output logic [PHASE_W-1:0] phase_snap_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)      cyc_cnt_o <= '0;
      else if (wrap_i) cyc_cnt_o <= cyc_cnt_o + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cyc_snap_o   <= '0;
         phase_snap_o <= '0;
      end else if (latch_i) begin
         cyc_snap_o   <= cyc_cnt_o;
         phase_snap_o <= phase_i;
      end
   end
endmodule

// File: rtl/carrier_nco.sv
module carrier_nco
   import nco_pkg::*;
#(
   parameter int ACC_W   = 27,
   parameter int ADDR_W  = 3,
   parameter int PHASE_W = 10,
   parameter int CYC_W   = 16,
   parameter bit REG_OUT = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ACC_W-1:0]   freq_word,
   input  logic               meas_latch,
   output logic signed [2:0]  cos_out,
   output logic signed [2:0]  sin_out,
   output logic [CYC_W-1:0]   cyc_snap,
   output logic [PHASE_W-1:0] phase_snap
);
   if (ADDR_W != 3) begin : g_bad_addr
      $error("carrier_nco: table supports exactly eight phase steps");
   end
   if (PHASE_W < ADDR_W || PHASE_W >= ACC_W) begin : g_bad_phase
      $error("carrier_nco: PHASE_W must lie between ADDR_W and ACC_W");
   end
   if (CYC_W < 2) begin : g_bad_cyc
      $error("carrier_nco: CYC_W too small");
   end

   logic [ACC_W-1:0] acc_q;
   logic             wrap;
   logic [CYC_W-1:0] cyc_cnt;
   level_t           cos_l, sin_l;

   nco_phase_acc #(.ACC_W(ACC_W)) u_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .freq_i (freq_word),
      .acc_o  (acc_q),
      .wrap_o (wrap)
   );

   nco_trig_lut #(.ADDR_W(ADDR_W), .REG_OUT(REG_OUT)) u_lut (
      .clk   (clk),
      .rst_n (rst_n),
      .idx_i (acc_q[ACC_W-1 -: ADDR_W]),
      .cos_o (cos_l),
      .sin_o (sin_l)
   );

   nco_meas_latch #(.CYC_W(CYC_W), .PHASE_W(PHASE_W)) u_meas (
      .clk          (clk),
      .rst_n        (rst_n),
      .wrap_i       (wrap),
      .phase_i      (acc_q[ACC_W-1 -: PHASE_W]),
      .latch_i      (meas_latch),
      .cyc_cnt_o    (cyc_cnt),
      .cyc_snap_o   (cyc_snap),
      .phase_snap_o (phase_snap)
   );

   assign cos_out = cos_l;
   assign sin_out = sin_l;
endmodule

// File: rtl/carrier_nco_chk.sv
module carrier_nco_chk #(
   parameter int ACC_W   = 27,
   parameter int PHASE_W = 10,
   parameter int CYC_W   = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic [ACC_W-1:0]   freq_word,
   input logic               meas_latch,
   input logic signed [2:0]  cos_out,
   input logic signed [2:0]  sin_out,
   input logic [CYC_W-1:0]   cyc_snap,
   input logic [PHASE_W-1:0] phase_snap,
   input logic [ACC_W-1:0]   acc_q,
   input logic               wrap,
   input logic [CYC_W-1:0]   cyc_cnt
);
   p_acc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> acc_q == $past(acc_q) + $past(freq_word));

   p_quadrature_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((cos_out == 3'sd3) || (cos_out == -3'sd3)) !=
      ((sin_out == 3'sd3) || (sin_out == -3'sd3)));

   p_cycle_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> cyc_cnt == $past(cyc_cnt) + 1'b1);

   p_cycle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap |=> $stable(cyc_cnt));

   p_snap_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
      meas_latch |=> (cyc_snap == $past(cyc_cnt)) &&
                     (phase_snap == $past(acc_q[ACC_W-1 -: PHASE_W])));

   p_snap_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !meas_latch |=> $stable(cyc_snap) && $stable(phase_snap));

   p_levels_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cos_out == 3'sd3 || cos_out == 3'sd1 || cos_out == -3'sd1 || cos_out == -3'sd3) &&
      (sin_out == 3'sd3 || sin_out == 3'sd1 || sin_out == -3'sd1 || sin_out == -3'sd3));
endmodule

bind carrier_nco carrier_nco_chk #(
   .ACC_W(ACC_W), .PHASE_W(PHASE_W), .CYC_W(CYC_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .freq_word(freq_word), .meas_latch(meas_latch),
   .cos_out(cos_out), .sin_out(sin_out), .cyc_snap(cyc_snap),
   .phase_snap(phase_snap), .acc_q(acc_q), .wrap(wrap), .cyc_cnt(cyc_cnt)
);

// File: tb/sim_carrier_nco.sv
`timescale 1ns/1ps
module sim_carrier_nco;
   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [26:0]        freq_word = '0;
   logic               meas_latch = 1'b0;
   logic signed [2:0]  cos_out, sin_out;
   logic [15:0]        cyc_snap;
   logic [9:0]         phase_snap;

   always #10 clk = ~clk;

   carrier_nco u0 (
      .clk(clk), .rst_n(rst_n), .freq_word(freq_word), .meas_latch(meas_latch),
      .cos_out(cos_out), .sin_out(sin_out), .cyc_snap(cyc_snap), .phase_snap(phase_snap)
   );

   typedef struct {
      logic signed [2:0] c;
      logic signed [2:0] s;
      logic [15:0]       cy;
      logic [9:0]        ph;
      string             tag;
   } exp_t;

   exp_t q[$];
   int n_cmp = 0;
   int n_bad = 0;

   // reference model state
   logic [26:0] m_acc = '0;
   logic [15:0] m_cnt = '0;
   logic [15:0] m_sc  = '0;
   logic [9:0]  m_sp  = '0;

   // R3 table: +3 +1 -1 -3 -3 -1 +1 +3
   function automatic logic signed [2:0] exp_cos(input logic [2:0] k);
      case (k)
         3'd0, 3'd7: return  3'sd3;
         3'd1, 3'd6: return  3'sd1;
         3'd2, 3'd5: return -3'sd1;
         default:    return -3'sd3;
      endcase
   endfunction

   // R4 table: +1 +3 +3 +1 -1 -3 -3 -1
   function automatic logic signed [2:0] exp_sin(input logic [2:0] k);
      case (k)
         3'd0, 3'd3: return  3'sd1;
         3'd1, 3'd2: return  3'sd3;
         3'd4, 3'd7: return -3'sd1;
         default:    return -3'sd3;
      endcase
   endfunction

   task automatic check(input string tag, input logic signed [2:0] c, input logic signed [2:0] s,
                        input logic [15:0] cy, input logic [9:0] ph);
      n_cmp++;
      if (cos_out !== c || sin_out !== s || cyc_snap !== cy || phase_snap !== ph) begin
         n_bad++;
         $display("FAIL %s: actual cos=%0d sin=%0d cyc=%0d ph=%0d expected cos=%0d sin=%0d cyc=%0d ph=%0d",
                  tag, cos_out, sin_out, cyc_snap, phase_snap, c, s, cy, ph);
      end
   endtask

   // driver: applies one clock of stimulus and pushes the expected result
   task automatic step(input logic [26:0] fw, input bit lt, input string tag, input bit chk);
      logic [27:0] sum;
      exp_t e;
      @(negedge clk);
      freq_word  = fw;
      meas_latch = lt;
      if (lt) begin
         m_sc = m_cnt;
         m_sp = m_acc[26:17];
      end
      sum   = {1'b0, m_acc} + {1'b0, fw};
      m_acc = sum[26:0];
      if (sum[27]) m_cnt = m_cnt + 16'd1;
      if (chk) begin
         e.c = exp_cos(m_acc[26:24]);
         e.s = exp_sin(m_acc[26:24]);
         e.cy = m_sc;
         e.ph = m_sp;
         e.tag = tag;
         q.push_back(e);
      end
   endtask

   // monitor: compares outputs after each edge against the queue
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(e.tag, e.c, e.s, e.cy, e.ph);
         end
      end
   end

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(200000 * 20);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual run still going, expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 in reset", 3'sd3, 3'sd1, 16'd0, 10'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", 3'sd3, 3'sd1, 16'd0, 10'd0);

      // one table step per clock, capture every clock: R2 R3 R4 R5 R6 R8
      for (int i = 0; i < 20; i++) step(27'd1 << 24, 1'b1, "R3/R4 step walk", 1'b1);

      // three steps per clock without capture, then capture: R6 hold
      for (int i = 0; i < 6; i++) step(27'd3 << 24, 1'b0, "R6 hold", 1'b1);
      step(27'd3 << 24, 1'b1, "R6 capture", 1'b1);

      // arbitrary word, then a nominal IF word mid-run: R2 R7
      for (int i = 0; i < 9; i++) step(27'd12345678, 1'b1, "R2 odd word", 1'b1);
      for (int i = 0; i < 12; i++) step(27'd33002000, 1'b1, "R7 word change", 1'b1);
      step(27'd0, 1'b1, "R7 zero word", 1'b1);
      step(27'd0, 1'b1, "R7 zero word", 1'b1);

      // half-cycle word toggles between opposite steps: R8
      for (int i = 0; i < 6; i++) step(27'd1 << 26, 1'b1, "R8 half cycle", 1'b1);

      // near full-scale word forces a carry almost every clock: R5 wrap
      for (int i = 0; i < 65600; i++) step(27'h7FF_FFFF, 1'b0, "R5", 1'b0);
      step(27'd5, 1'b1, "R5 counter wrap", 1'b1);
      step(27'd5, 1'b1, "R5 after wrap", 1'b1);

      @(negedge clk);
      @(negedge clk);
      finish_run();
   end
endmodule